// File: doc/BRIEF.md
# Row Circuit Reservation Unit

This block arbitrates and distributes circuit reservations along one row (or one column) of a mesh that uses dimension-order routing. Every node on the row may present a request that names a destination index on the same row. In each cycle a single round-robin choice, identical at every node, selects one eligible source. That source's index and its destination are then known row-wide. Every node on the span from source to destination records the pair in its reservation queue for the direction of travel. All of these queues are written at the same clock edge, so all nodes hold their reservations in the same order.

Each node keeps two reservation queues, one for travel toward higher indices and one for travel toward lower indices. A full queue raises its flow-control bit. Any request whose span crosses a full queue of its direction cannot win. When the tail flit of the active circuit has been sent, the user pops the queue. A control register holds the active reservation for the crossbar. It is reloaded from the second queue entry at the pop edge, so the next circuit is ready in the following cycle.

Top module: `row_resv_net`

## Requirements
- R1: After reset, arb_win is zero, bc_vld is 0, every full bit is 0, every act_vld bit is 0, and the round-robin search starts at node 0.
- R2: Node s is eligible when req_vld[s] is 1, its destination differs from s, and no node on the inclusive span between s and the destination has its full bit set for that direction. A request whose destination equals the source is never granted and enqueues nothing.
- R3: The winner is the first eligible node found by searching upward from the pointer, wrapping past NODES-1 to 0. After a grant the pointer moves to the winner plus one, wrapping to 0. In a cycle with no eligible node the pointer does not move.
- R4: arb_win is the one-hot code of the winner in the same cycle as the request, and zero when no node is eligible.
- R5: In the cycle after a grant, bc_vld is 1, bc_src holds the winner and bc_dst holds its destination. Otherwise bc_vld is 0.
- R6: A grant whose destination is above its source uses direction 0; otherwise it uses direction 1. At the grant edge, each node i inside the inclusive span of source and destination appends the entry {src, dst} to queue d*NODES+i, where d is the direction and src takes the upper IW bits. No other queue changes.
- R7: full[d*NODES+i] is 1 exactly when that queue holds DEPTH entries, and a queue never takes an entry while full.
- R8: A pop[k] pulse removes the head of queue k at the clock edge and is ignored when the queue is empty. A pop and an append in the same cycle both take effect.
- R9: act_vld[k] and act_ent[k*2*IW +: 2*IW] show the head of queue k from the edge at which that entry becomes head. After a pop, the next entry appears in the following cycle, in append order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | NODES | Request present, one bit per node |
| req_dst | input | NODES*IW | Destination index per node, node s at bits s*IW |
| arb_win | output | NODES | One-hot winner of the current cycle |
| bc_vld | output | 1 | Registered broadcast valid |
| bc_src | output | IW | Broadcast source index |
| bc_dst | output | IW | Broadcast destination index |
| pop | input | 2*NODES | Tail flit sent, one per queue (d*NODES+i) |
| full | output | 2*NODES | Flow-control bits, one per queue |
| act_vld | output | 2*NODES | Control register holds a reservation |
| act_ent | output | 2*NODES*2*IW | Active {src, dst} per queue |

## Verification
The hardest situation to reach is a request that is blocked by a full queue in the middle of its span, while requests in the other direction, or requests whose spans stop short of that node, still win in the same cycle. Directed runs fill every upward queue by repeating one full-length grant with no pops, then issue crossing and opposite-direction requests. Random phases with a low pop rate keep many queues at the full boundary, and phases with a high pop rate exercise pop and append in the same cycle and the promotion of the second entry.

// File: rtl/row_resv_pkg.sv
package row_resv_pkg;

  // direction of travel along the row
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;

  // true when i lies on the inclusive span between a and b
  function automatic logic in_span(input int unsigned i, input int unsigned a,
                                   input int unsigned b);
    int unsigned lo;
    int unsigned hi;
    lo = (a < b) ? a : b;
    hi = (a < b) ? b : a;
    return (i >= lo) && (i <= hi);
  endfunction

endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  elig,
  output logic [N-1:0]  win,
  output logic          any,
  output logic [IW-1:0] widx
);

  logic [IW-1:0] ptr;

  always_comb begin
    any  = 1'b0;
    widx = '0;
    for (int unsigned k = 0; k < N; k++) begin
      int unsigned c;
      c = int'(ptr) + k;
      if (c >= N) c = c - N;
      if (!any && elig[c]) begin
        any  = 1'b1;
        widx = IW'(c);
      end
    end
    win = '0;
    if (any) win[widx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (any) begin
      ptr <= (int'(widx) == N - 1) ? '0 : widx + 1'b1;
    end
  end

endmodule

// File: rtl/resv_fifo.sv
module resv_fifo #(
  parameter int DEPTH = 4,
  parameter int EW    = 6,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [EW-1:0] wdata,
  input  logic          pop,
  output logic          full,
  output logic          ctl_vld,
  output logic [EW-1:0] ctl_data
);

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr, rd_nxt;
  logic [CW-1:0] cnt;
  logic          push_ok, pop_ok;
  logic          nxt_vld;
  logic [EW-1:0] nxt_data;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign full    = (int'(cnt) == DEPTH);
  assign push_ok = push && !full;
  assign pop_ok  = pop && (cnt != '0);
  assign rd_nxt  = bump(rd_ptr);

  // storage: single write port, no reset, so it maps to distributed or block RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= rd_nxt;
      if (push_ok && !pop_ok)      cnt <= cnt + 1'b1;
      else if (pop_ok && !push_ok) cnt <= cnt - 1'b1;
    end
  end

  // next crossbar setting, prepared from the second entry before teardown
  always_comb begin
    nxt_vld  = ctl_vld;
    nxt_data = ctl_data;
    if (pop_ok) begin
      if (int'(cnt) >= 2) begin
        nxt_vld  = 1'b1;
        nxt_data = mem[rd_nxt];
      end else begin
        nxt_vld  = push_ok;
        nxt_data = wdata;
      end
    end else if (cnt == '0) begin
      nxt_vld  = push_ok;
      nxt_data = wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_vld  <= 1'b0;
      ctl_data <= '0;
    end else begin
      ctl_vld  <= nxt_vld;
      ctl_data <= nxt_data;
    end
  end

endmodule

// File: rtl/row_resv_net.sv
module row_resv_net
  import row_resv_pkg::*;
#(
  parameter int NODES = 8,
  parameter int DEPTH = 4,
  localparam int IW   = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int EW   = 2 * IW,
  localparam int NQ   = 2 * NODES
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NODES-1:0]   req_vld,
  input  logic [NODES*IW-1:0] req_dst,
  output logic [NODES-1:0]   arb_win,
  output logic               bc_vld,
  output logic [IW-1:0]      bc_src,
  output logic [IW-1:0]      bc_dst,
  input  logic [NQ-1:0]      pop,
  output logic [NQ-1:0]      full,
  output logic [NQ-1:0]      act_vld,
  output logic [NQ*EW-1:0]   act_ent
);

  logic [NODES-1:0] elig;
  logic             any;
  logic [IW-1:0]    widx;
  logic [IW-1:0]    wdst;
  dir_e             wdir;
  logic [EW-1:0]    wentry;
  logic [NQ-1:0]    enq_vec;

  // eligibility: valid, real travel, and no full queue on the span
  for (genvar s = 0; s < NODES; s++) begin : g_elig
    logic [IW-1:0] d;
    dir_e          dr;
    logic          blk;
    assign d  = req_dst[s*IW +: IW];
    assign dr = (int'(d) > s) ? DIR_UP : DIR_DOWN;
    always_comb begin
      blk = 1'b0;
      for (int unsigned j = 0; j < NODES; j++) begin
        if (in_span(j, s, int'(d)) && full[int'(dr) * NODES + j]) blk = 1'b1;
      end
    end
    assign elig[s] = req_vld[s] && (int'(d) != s) && (int'(d) < NODES) && !blk;
  end

  rr_pick #(.N(NODES)) u_arb (
    .clk  (clk),
    .rst  (rst),
    .elig (elig),
    .win  (arb_win),
    .any  (any),
    .widx (widx)
  );

  assign wdst   = req_dst[widx*IW +: IW];
  assign wdir   = (wdst > widx) ? DIR_UP : DIR_DOWN;
  assign wentry = {widx, wdst};

  // every node on the span appends in the same edge
  for (genvar dd = 0; dd < 2; dd++) begin : g_dir
    for (genvar i = 0; i < NODES; i++) begin : g_node
      assign enq_vec[dd*NODES + i] = any && (int'(wdir) == dd) &&
                                     in_span(i, int'(widx), int'(wdst));
    end
  end

  for (genvar k = 0; k < NQ; k++) begin : g_q
    resv_fifo #(.DEPTH(DEPTH), .EW(EW)) u_fifo (
      .clk      (clk),
      .rst      (rst),
      .push     (enq_vec[k]),
      .wdata    (wentry),
      .pop      (pop[k]),
      .full     (full[k]),
      .ctl_vld  (act_vld[k]),
      .ctl_data (act_ent[k*EW +: EW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bc_vld <= 1'b0;
      bc_src <= '0;
      bc_dst <= '0;
    end else begin
      bc_vld <= any;
      if (any) begin
        bc_src <= widx;
        bc_dst <= wdst;
      end
    end
  end

endmodule

// File: rtl/row_resv_chk.sv
module row_resv_chk #(
  parameter int NODES = 8,
  localparam int NQ   = 2 * NODES
) (
  input logic             clk,
  input logic             rst,
  input logic [NODES-1:0] req_vld,
  input logic [NODES-1:0] arb_win,
  input logic             bc_vld,
  input logic [NQ-1:0]    pop,
  input logic [NQ-1:0]    full,
  input logic [NQ-1:0]    enq_vec,
  input logic [NQ-1:0]    act_vld
);

  // R4
  win_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(arb_win));

  // R2
  win_has_req_chk: assert property (@(posedge clk) disable iff (rst)
    (arb_win & ~req_vld) == '0);

  // R5
  bcast_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (arb_win != '0) |=> bc_vld);

  // R5
  bcast_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (arb_win == '0) |=> !bc_vld);

  for (genvar k = 0; k < NQ; k++) begin : g_k
    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
      !(enq_vec[k] && full[k]));

    // R7
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (full[k] && !pop[k]) |=> full[k]);

    // R9
    act_idle_chk: assert property (@(posedge clk) disable iff (rst)
      (!act_vld[k] && !enq_vec[k]) |=> !act_vld[k]);
  end

endmodule

bind row_resv_net row_resv_chk #(.NODES(NODES)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .req_vld (req_vld),
  .arb_win (arb_win),
  .bc_vld  (bc_vld),
  .pop     (pop),
  .full    (full),
  .enq_vec (enq_vec),
  .act_vld (act_vld)
);

// File: tb/row_resv_net_bench.sv
module row_resv_net_bench;

  localparam int N  = 8;
  localparam int D  = 4;
  localparam int IW = 3;
  localparam int EW = 6;
  localparam int NQ = 2 * N;

  logic              clk = 1'b0;
  logic              rst;
  logic [N-1:0]      req_vld;
  logic [N*IW-1:0]   req_dst;
  logic [N-1:0]      arb_win;
  logic              bc_vld;
  logic [IW-1:0]     bc_src, bc_dst;
  logic [NQ-1:0]     pop;
  logic [NQ-1:0]     full;
  logic [NQ-1:0]     act_vld;
  logic [NQ*EW-1:0]  act_ent;

  always #4 clk = ~clk;

  row_resv_net #(.NODES(N), .DEPTH(D)) u_row_resv_net (
    .clk(clk), .rst(rst), .req_vld(req_vld), .req_dst(req_dst),
    .arb_win(arb_win), .bc_vld(bc_vld), .bc_src(bc_src), .bc_dst(bc_dst),
    .pop(pop), .full(full), .act_vld(act_vld), .act_ent(act_ent)
  );

  // reference model state
  int qs [NQ][D];
  int qd [NQ][D];
  int qc [NQ];
  int ptr;
  int exp_bcv, exp_bcs, exp_bcd;
  int vecs, bad;
  bit done;

  task automatic chk(input string tag, input logic [127:0] a, input logic [127:0] e);
    vecs++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
    end
  endtask

  function automatic bit elig_m(input int s);
    int d, base, lo, hi;
    if (!req_vld[s]) return 0;
    d = int'(req_dst[s*IW +: IW]);
    if (d == s) return 0;
    base = (d > s) ? 0 : N;
    lo = (d > s) ? s : d;
    hi = (d > s) ? d : s;
    for (int j = lo; j <= hi; j++) if (qc[base + j] == D) return 0;
    return 1;
  endfunction

  function automatic int pick_m();
    for (int k = 0; k < N; k++) begin
      int c;
      c = (ptr + k) % N;
      if (elig_m(c)) return c;
    end
    return -1;
  endfunction

  // registered outputs against model (R5, R7, R9)
  task automatic check_regs();
    logic [NQ-1:0] ef, ev;
    for (int k = 0; k < NQ; k++) begin
      ef[k] = (qc[k] == D);
      ev[k] = (qc[k] > 0);
    end
    chk("R7 full", 128'(full), 128'(ef));
    chk("R9 act_vld", 128'(act_vld), 128'(ev));
    for (int k = 0; k < NQ; k++) begin
      if (qc[k] > 0)
        chk("R9 act_ent", 128'(act_ent[k*EW +: EW]), 128'((qs[k][0] << IW) | qd[k][0]));
    end
    chk("R5 bc_vld", 128'(bc_vld), 128'(exp_bcv));
    if (exp_bcv != 0) begin
      chk("R5 bc_src", 128'(bc_src), 128'(exp_bcs));
      chk("R5 bc_dst", 128'(bc_dst), 128'(exp_bcd));
    end
  endtask

  // settle the combinational winner, check it, then advance the model
  task automatic eval_cycle();
    int w, d, base, lo, hi;
    logic [N-1:0] ew;
    #1;
    w = pick_m();
    ew = '0;
    if (w >= 0) ew[w] = 1'b1;
    chk("R3 R4 arb_win", 128'(arb_win), 128'(ew));
    // R8: pops on the pre-edge state
    for (int k = 0; k < NQ; k++) begin
      if (pop[k] && qc[k] > 0) begin
        for (int m = 0; m < D - 1; m++) begin
          qs[k][m] = qs[k][m+1];
          qd[k][m] = qd[k][m+1];
        end
        qc[k]--;
      end
    end
    // R6: appends along the span
    if (w >= 0) begin
      d = int'(req_dst[w*IW +: IW]);
      base = (d > w) ? 0 : N;
      lo = (d > w) ? w : d;
      hi = (d > w) ? d : w;
      for (int j = lo; j <= hi; j++) begin
        qs[base+j][qc[base+j]] = w;
        qd[base+j][qc[base+j]] = d;
        qc[base+j]++;
      end
      ptr = (w + 1) % N;
      exp_bcv = 1; exp_bcs = w; exp_bcd = d;
    end else begin
      exp_bcv = 0;
    end
  endtask

  task automatic rand_cycle(input int preq, input int ppop);
    @(negedge clk);
    check_regs();
    for (int s = 0; s < N; s++) begin
      int d;
      req_vld[s] = (($urandom % 100) < preq);
      d = $urandom % N;
      if (d == s && ($urandom % 4) != 0) d = (s + 1) % N;
      req_dst[s*IW +: IW] = IW'(d);
    end
    for (int k = 0; k < NQ; k++) pop[k] = (($urandom % 100) < ppop);
    eval_cycle();
  endtask

  task automatic dir_cycle(input logic [N-1:0] v, input logic [N*IW-1:0] dd,
                           input logic [NQ-1:0] p);
    @(negedge clk);
    check_regs();
    req_vld = v;
    req_dst = dd;
    pop = p;
    eval_cycle();
  endtask

  function automatic logic [N*IW-1:0] one_dst(input int s, input int d);
    logic [N*IW-1:0] r;
    r = '0;
    r[s*IW +: IW] = IW'(d);
    return r;
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    vecs = 0; bad = 0; done = 0;
    ptr = 0; exp_bcv = 0;
    for (int k = 0; k < NQ; k++) qc[k] = 0;
    rst = 1'b1; req_vld = '0; req_dst = '0; pop = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    @(negedge clk);
    chk("R1 arb_win", 128'(arb_win), 128'(0));
    chk("R1 bc_vld", 128'(bc_vld), 128'(0));
    chk("R1 full", 128'(full), 128'(0));
    chk("R1 act_vld", 128'(act_vld), 128'(0));

    // R2: self destination is never granted
    dir_cycle(8'b0000_0100, one_dst(2, 2), '0);
    // R3: all nodes request, search starts at 0 and rotates with wrap
    for (int r = 0; r < 10; r++) begin
      logic [N*IW-1:0] dd;
      dd = '0;
      for (int s = 0; s < N; s++) dd[s*IW +: IW] = IW'((s + 3) % N);
      dir_cycle('1, dd, '1);
    end
    // drain everything
    for (int r = 0; r < D + 2; r++) dir_cycle('0, '0, '1);

    // R7, R2: fill every upward queue with 0 -> 7, no pops
    for (int r = 0; r < D + 2; r++) dir_cycle(8'b0000_0001, one_dst(0, 7), '0);
    // upward blocked, downward from 6 to 1 still wins
    dir_cycle(8'b0100_0100, one_dst(2, 5) | one_dst(6, 1), '0);
    // R8: pop node 4 upward only, 4 -> 5 still blocked by node 5
    dir_cycle('0, '0, 16'h0010);
    dir_cycle(8'b0001_0000, one_dst(4, 5), '0);
    // R8, R9: pop all upward with a simultaneous downward append
    for (int r = 0; r < D + 1; r++)
      dir_cycle(8'b1000_0000, one_dst(7, 0), 16'h00ff);
    for (int r = 0; r < D + 2; r++) dir_cycle('0, '0, '1);

    // random phases: light pops keep queues at the full boundary
    for (int r = 0; r < 1500; r++) rand_cycle(40, 8);
    for (int r = 0; r < 1500; r++) rand_cycle(60, 50);
    for (int r = 0; r < 1000; r++) rand_cycle(15, 25);

    @(negedge clk);
    check_regs();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

endmodule